// File: doc/BRIEF.md
# Auxiliary Supply and Ground Switch Controller

This block decides, every clock cycle, how each of three auxiliary supply outputs and three ground-cut switches should be set. A supply channel can be fed straight from the storage node, fed from a shared regulator, left floating or pulled to ground. A ground-cut switch either closes the return path of a peripheral to ground or leaves it open. The decision uses three system flags and a per-channel configuration. The flags are: battery voltage sufficient, storage above the application maximum, and harvester power low.

Each supply channel has a 2-bit mode, an enable bit and a harvester-low disable bit. The mode chooses one of four behaviours: always direct, always regulated, regulated only above the limit with a floating off-state, or the same with a grounded off-state. Each ground channel has an enable bit, a 1-bit mode and a harvester-low disable bit. With mode 1 the switch opens automatically while the storage voltage is above the application maximum.

All switch outputs are registered. Whenever a supply channel moves between its direct and regulated paths, both paths are open for one cycle in between. The regulator voltage selection passes through the block unchanged.

Top module: `aux_rail_ctrl`

## Requirements
- R1: While `batt_ok` is 0, every `sup_direct`, `sup_reg` and `gnd_close` bit is 0 one cycle later, whatever the enables are.
- R2: A supply channel in mode 2'b00 that is on drives `sup_direct`=1 and `sup_reg`=0. A channel is on when its enable is 1, `batt_ok` is 1, and it is not disabled by R6. Channel i's mode is `sup_mode[2i+1:2i]`.
- R3: A channel that is on in mode 2'b01 drives `sup_reg`=1 and `sup_direct`=0.
- R4: A channel that is on in mode 2'b10 or 2'b11 uses the regulated path while `over_max` is 1 and the direct path while it is 0.
- R5: A channel that is not on drives `sup_tie`=1 in mode 2'b11, and `sup_tie`=0 in every other mode, so that the output floats. `sup_tie` is never 1 together with `sup_direct` or `sup_reg`.
- R6: When a supply's bit in `sup_hl_dis` is 1 and `hrv_low` is 1, that channel is off. Other channels are unaffected.
- R7: A ground switch closes (`gnd_close`=1) when its enable is 1 and `batt_ok` is 1. If its `gnd_mode` bit is 1, it is open while `over_max` is 1.
- R8: When a ground channel's bit in `gnd_hl_dis` is 1 and `hrv_low` is 1, that switch is open.
- R9: `sup_direct` and `sup_reg` of one channel are never 1 together. A change from one path to the other passes through exactly one cycle with both at 0.
- R10: `ldo_vsel_out` equals `ldo_vsel_in` in the same cycle.
- R11: Switch outputs are registered: a change of inputs appears after the next rising clock edge. A synchronous active-low reset clears all switch outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| batt_ok | input | 1 | Storage voltage above battery-minimum (hysteresis flag) |
| over_max | input | 1 | Storage voltage above application maximum |
| hrv_low | input | 1 | Harvester power below minimum |
| sup_mode | input | 6 | 2-bit mode per supply channel |
| sup_en | input | 3 | Supply channel enables |
| sup_hl_dis | input | 3 | Per-supply disable during harvester-low |
| gnd_mode | input | 3 | Per-ground-switch auto-open above maximum |
| gnd_en | input | 3 | Ground switch enables |
| gnd_hl_dis | input | 3 | Per-ground-switch open during harvester-low |
| ldo_vsel_in | input | 3 | Regulator voltage selection |
| sup_direct | output | 3 | Connect channel to storage |
| sup_reg | output | 3 | Connect channel to shared regulator |
| sup_tie | output | 3 | Tie channel output to ground |
| gnd_close | output | 3 | Close ground-cut switch |
| ldo_vsel_out | output | 3 | Regulator voltage selection, passed through |

## Verification
The situation hardest to reach from the ports is a path change while the channel stays on. Mode and enable must stay constant while only `over_max` flips. The bench does this for channels held in the automatic modes. It samples after the first edge to see the dead cycle with both paths open, and after the second edge to see the new path, in both directions. It also mixes modes and disable bits across channels, so that one channel misbehaving cannot hide behind the others.

// File: rtl/aux_rail_pkg.sv
// Shared types for the auxiliary rail controller.
package aux_rail_pkg;
    // Supply channel mode encoding.
    typedef enum logic [1:0] {
        MODE_DIRECT     = 2'b00,
        MODE_REGULATED  = 2'b01,
        MODE_AUTO_FLOAT = 2'b10,
        MODE_AUTO_GND   = 2'b11
    } sup_mode_e;
endpackage

// File: rtl/aux_sup_chan.sv
// One auxiliary supply channel: picks direct, regulated or off, with one dead
// cycle between the two paths, and a grounded off-state in mode 11.
// Assumes the system flags are synchronous to clk.
module aux_sup_chan
    import aux_rail_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       batt_ok,
    input  logic       over_max,
    input  logic       hrv_low,
    input  logic [1:0] mode,
    input  logic       en,
    input  logic       hl_dis,
    output logic       direct_q,
    output logic       regl_q,
    output logic       tie_q
);
    sup_mode_e m;
    logic      on;
    logic      want_regl;
    logic      want_direct;

    // Decode the requested path for this cycle.
    always_comb begin
        m           = sup_mode_e'(mode);
        on          = en && batt_ok && !(hl_dis && hrv_low);
        want_regl   = on && ((m == MODE_REGULATED) || (mode[1] && over_max));
        want_direct = on && !want_regl;
    end

    // Register switches; a path closes only once the other one is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            direct_q <= 1'b0;
            regl_q   <= 1'b0;
            tie_q    <= 1'b0;
        end else begin
            direct_q <= want_direct && !regl_q;
            regl_q   <= want_regl && !direct_q;
            tie_q    <= !on && (m == MODE_AUTO_GND);
        end
    end

    AST_PATH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(direct_q && regl_q)); // R9
    AST_BBM_TO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        regl_q |-> !$past(direct_q)); // R9
    AST_BBM_TO_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        direct_q |-> !$past(regl_q)); // R9
    AST_TIE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        tie_q |-> !(direct_q || regl_q)); // R5
    AST_BATT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !batt_ok |=> !(direct_q || regl_q)); // R1
    AST_HL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (hl_dis && hrv_low) |=> !(direct_q || regl_q)); // R6
endmodule

// File: rtl/aux_gnd_chan.sv
// One ground-cut switch: closes when enabled, opens on low battery, on
// harvester-low if so configured, and above the maximum in mode 1.
// Assumes the system flags are synchronous to clk.
module aux_gnd_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic batt_ok,
    input  logic over_max,
    input  logic hrv_low,
    input  logic mode,
    input  logic en,
    input  logic hl_dis,
    output logic close_q
);
    // Register the switch state from the enable and the opening conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) close_q <= 1'b0;
        else        close_q <= en && batt_ok && !(hl_dis && hrv_low) && !(mode && over_max);
    end

    AST_GND_AUTO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && over_max) |=> !close_q); // R7
    AST_GND_HL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hl_dis && hrv_low) |=> !close_q); // R8
    AST_GND_BATT: assert property (@(posedge clk) disable iff (!rst_n)
        !batt_ok |=> !close_q); // R1
endmodule

// File: rtl/aux_rail_ctrl.sv
// Top of the auxiliary rail controller: replicates the supply and ground
// channels and passes the regulator voltage selection through.
// Assumes all inputs are synchronous to clk.
module aux_rail_ctrl #(
    parameter int N_SUP  = 3,
    parameter int N_GND  = 3,
    parameter int VSEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 batt_ok,
    input  logic                 over_max,
    input  logic                 hrv_low,
    input  logic [2*N_SUP-1:0]   sup_mode,
    input  logic [N_SUP-1:0]     sup_en,
    input  logic [N_SUP-1:0]     sup_hl_dis,
    input  logic [N_GND-1:0]     gnd_mode,
    input  logic [N_GND-1:0]     gnd_en,
    input  logic [N_GND-1:0]     gnd_hl_dis,
    input  logic [VSEL_W-1:0]    ldo_vsel_in,
    output logic [N_SUP-1:0]     sup_direct,
    output logic [N_SUP-1:0]     sup_reg,
    output logic [N_SUP-1:0]     sup_tie,
    output logic [N_GND-1:0]     gnd_close,
    output logic [VSEL_W-1:0]    ldo_vsel_out
);
    localparam int MODE_W = 2;

    // One controller per supply channel.
    for (genvar i = 0; i < N_SUP; i++) begin : g_sup
        aux_sup_chan u_sup (
            .clk      (clk),
            .rst_n    (rst_n),
            .batt_ok  (batt_ok),
            .over_max (over_max),
            .hrv_low  (hrv_low),
            .mode     (sup_mode[MODE_W*i +: MODE_W]),
            .en       (sup_en[i]),
            .hl_dis   (sup_hl_dis[i]),
            .direct_q (sup_direct[i]),
            .regl_q   (sup_reg[i]),
            .tie_q    (sup_tie[i])
        );
    end

    // One controller per ground-cut switch.
    for (genvar j = 0; j < N_GND; j++) begin : g_gnd
        aux_gnd_chan u_gnd (
            .clk      (clk),
            .rst_n    (rst_n),
            .batt_ok  (batt_ok),
            .over_max (over_max),
            .hrv_low  (hrv_low),
            .mode     (gnd_mode[j]),
            .en       (gnd_en[j]),
            .hl_dis   (gnd_hl_dis[j]),
            .close_q  (gnd_close[j])
        );
    end

    // Regulator level selection is not interpreted here.
    assign ldo_vsel_out = ldo_vsel_in;

    always_comb begin
        AST_VSEL_PASS: assert (ldo_vsel_out == ldo_vsel_in); // R10
    end
endmodule

// File: tb/sim_aux_rail_ctrl.sv
module sim_aux_rail_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       batt_ok = 1'b0, over_max = 1'b0, hrv_low = 1'b0;
    logic [5:0] sup_mode = '0;
    logic [2:0] sup_en = '0, sup_hl_dis = '0;
    logic [2:0] gnd_mode = '0, gnd_en = '0, gnd_hl_dis = '0;
    logic [2:0] vsel_in = '0;
    logic [2:0] sup_direct, sup_reg, sup_tie, gnd_close, vsel_out;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    aux_rail_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .batt_ok(batt_ok), .over_max(over_max),
        .hrv_low(hrv_low), .sup_mode(sup_mode), .sup_en(sup_en),
        .sup_hl_dis(sup_hl_dis), .gnd_mode(gnd_mode), .gnd_en(gnd_en),
        .gnd_hl_dis(gnd_hl_dis), .ldo_vsel_in(vsel_in),
        .sup_direct(sup_direct), .sup_reg(sup_reg), .sup_tie(sup_tie),
        .gnd_close(gnd_close), .ldo_vsel_out(vsel_out)
    );

    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; batt_ok = 1'b1; sup_en = 3'b111; gnd_en = 3'b111;
        tick(); tick();
        chk("R11 reset direct", sup_direct, 3'b000);
        chk("R11 reset reg", sup_reg, 3'b000);
        chk("R11 reset gnd", gnd_close, 3'b000);
        sup_en = '0; gnd_en = '0; rst_n = 1'b1;
        tick();
    endtask

    task automatic t_direct();
        sup_mode = 6'b00_00_00; sup_en = 3'b111;
        #1 chk("R11 no change before edge", sup_direct, 3'b000);
        tick();
        chk("R2 direct", sup_direct, 3'b111);
        chk("R2 reg off", sup_reg, 3'b000);
        sup_en = 3'b000; tick();
        chk("R5 modes 00 float", sup_tie, 3'b000);
    endtask

    task automatic t_regulated();
        sup_mode = 6'b01_01_01; sup_en = 3'b101; tick();
        chk("R3 reg", sup_reg, 3'b101);
        chk("R3 direct off", sup_direct, 3'b000);
        sup_en = 3'b000; tick();
    endtask

    task automatic t_auto();
        sup_mode = 6'b10_11_10; sup_en = 3'b111; over_max = 1'b0; tick();
        chk("R4 below max direct", sup_direct, 3'b111);
        over_max = 1'b1; tick();
        chk("R9 dead cycle direct", sup_direct, 3'b000);
        chk("R9 dead cycle reg", sup_reg, 3'b000);
        tick();
        chk("R4 above max reg", sup_reg, 3'b111);
        over_max = 1'b0; tick();
        chk("R9 dead cycle back", sup_reg | sup_direct, 3'b000);
        tick();
        chk("R4 back to direct", sup_direct, 3'b111);
    endtask

    task automatic t_offstate();
        // ch0 mode 11, ch1 mode 10, ch2 mode 00
        sup_mode = 6'b00_10_11; sup_en = 3'b000; tick();
        chk("R5 tie only mode 11", sup_tie, 3'b001);
        chk("R5 no path when off", sup_direct | sup_reg, 3'b000);
        sup_en = 3'b001; tick();
        chk("R5 tie released when on", sup_tie, 3'b000);
    endtask

    task automatic t_harvester();
        sup_mode = 6'b00_00_00; sup_en = 3'b111; sup_hl_dis = 3'b010;
        hrv_low = 1'b1; tick();
        chk("R6 hrv-low disables ch1", sup_direct, 3'b101);
        hrv_low = 1'b0; tick();
        chk("R6 recovered", sup_direct, 3'b111);
        sup_hl_dis = '0;
    endtask

    task automatic t_battery();
        gnd_en = 3'b111; gnd_mode = '0; batt_ok = 1'b0; tick();
        chk("R1 supplies off", sup_direct | sup_reg, 3'b000);
        chk("R1 grounds open", gnd_close, 3'b000);
        batt_ok = 1'b1; tick();
        chk("R1 restored", sup_direct, 3'b111);
    endtask

    task automatic t_ground();
        gnd_en = 3'b101; gnd_mode = 3'b000; over_max = 1'b0; tick();
        chk("R7 closes when enabled", gnd_close, 3'b101);
        gnd_mode = 3'b100; over_max = 1'b1; tick();
        chk("R7 auto-open above max", gnd_close, 3'b001);
        gnd_hl_dis = 3'b001; hrv_low = 1'b1; tick();
        chk("R8 hrv-low opens", gnd_close, 3'b000);
        hrv_low = 1'b0; over_max = 1'b0; tick();
        chk("R7 R8 reclosed", gnd_close, 3'b101);
    endtask

    task automatic t_vsel();
        vsel_in = 3'b101; #1 chk("R10 pass", vsel_out, 3'b101);
        vsel_in = 3'b010; #1 chk("R10 pass", vsel_out, 3'b010);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick();
        t_reset();
        t_direct();
        t_regulated();
        t_auto();
        t_offstate();
        t_harvester();
        t_battery();
        t_ground();
        t_vsel();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule